// File: doc/BRIEF.md
# Key-Locked Banked Configuration Register Block

This block is the configuration side of a multi-function I/O controller. A host reaches it through two byte-wide ports: an index port at a base address and a data port at the base address plus one. After reset the block is locked, and the data port has no effect. A fixed byte key written twice in a row to the index port opens configuration mode. In that mode the host writes a register number to the index port and then reads or writes that register through the data port. Writing the close key to the index port locks the block again.

A small set of global registers gives the chip identity, revision, a live power-enable summary and two scratch-style control bytes. Every other register belongs to one of nine logical devices. A logical-device-number register selects which device bank those indices reach. Each bank holds an enable bit, a 16-bit I/O base, and an interrupt selection. The keyboard bank also has a second interrupt selection. The floppy and parallel banks have a DMA channel selection, and the floppy bank has two mode bytes. All bank contents drive output ports at all times, so the peripherals are configured directly from them.

A strap input, sampled while reset is asserted, selects one of two base addresses for the port pair.

Top module: `kcfg_top`

## Requirements
- R1: Configuration mode opens only after two consecutive writes of 0x55 to the index port. Any other index-port write while locked, including a single 0x55 followed by a different byte, restarts the key count.
- R2: While in configuration mode, a write of 0xAA to the index port returns the block to the locked state and does not change the index register.
- R3: While locked, writes to the data port change no register. Reads of either port return 0xFF.
- R4: The strap `base_sel_i` is sampled during reset. Value 0 places the port pair at 0x3F0/0x3F1 and value 1 places it at 0x370/0x371. Accesses to any other address are ignored, and reads of them return 0xFF.
- R5: The register index is written at the base address, and the selected register is accessed at base+1. While unlocked, a read of the index port returns the current index.
- R6: Global index 0x20 reads 0x02 and index 0x21 reads the revision parameter (default 0x01). Both ignore writes. Indices 0x23 and 0x24 are read/write bytes.
- R7: Index 0x07 is the logical device number, with encoding floppy=0, IDE1=1, IDE2=2, parallel=3, serial1=4, serial2=5, RTC=6, keyboard=7, aux=8. Writes of values 0..8 are stored, and writes above 8 are ignored.
- R8: In the selected bank, index 0x30 bit 0 is the device enable, 0x60 is the base address high byte, 0x61 is the base address low byte, and 0x70 is the primary interrupt selection. A write reaches only the bank that the device number selects, and each bank drives its own output fields.
- R9: Index 0x72 (secondary interrupt) exists only in bank 7. Index 0x74 (DMA channel) exists only in banks 0 and 3. In any other bank these indices read 0x00 and ignore writes.
- R10: Bank 0 implements read/write bytes at 0x90 (mode) and 0x91 (option), which appear on their own output ports. Other banks read 0x00 at these indices.
- R11: Index 0x22 reads bit n = enable bit of device n for n = 0..5, with bits 7:6 zero. Writes to it are ignored.
- R12: Unimplemented indices read 0x00, and writes to them change nothing.
- R13: Synchronous reset clears every enable bit, address, selection, mode byte, the index register and the device number, and leaves the block locked.
- R14: A write takes effect at the clock edge where `wr_i` is high and is visible on the outputs just after it. Read data is registered and appears on `rdata_o` just after the edge where `rd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel_i | input | 1 | Base address strap, sampled during reset |
| addr_i | input | 16 | Host I/O address |
| wr_i | input | 1 | Host write strobe, one cycle per byte |
| rd_i | input | 1 | Host read strobe, one cycle per byte |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data |
| dev_active_o | output | 9 | Enable bit of each logical device |
| dev_base_o | output | 144 | 16-bit base per device, device n at bits [16n+15:16n] |
| dev_irq_o | output | 72 | Primary interrupt selection per device, device n at bits [8n+7:8n] |
| kbd_irq2_o | output | 8 | Keyboard secondary interrupt selection |
| fdc_dma_o | output | 8 | Floppy DMA channel selection |
| par_dma_o | output | 8 | Parallel port DMA channel selection |
| fdc_mode_o | output | 8 | Floppy mode byte |
| fdc_opt_o | output | 8 | Floppy option byte |

## Verification
Every register write lands at the rising edge that carries `wr_i`, and its output field changes right after that edge. Read data takes one registered stage, so it is valid after the edge that carries `rd_i`. The bench changes inputs on falling edges and holds each strobe for exactly one cycle. It then samples outputs and `rdata_o` at the next falling edge, which falls halfway between the edge that did the work and the next one. A configuration access is always an index-port write followed by a data-port access, two cycles in all, so every expected value is checked once the second of those cycles has completed.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;

    localparam int DATA_W = 8;

    localparam logic [7:0] KEY_OPEN  = 8'h55;
    localparam logic [7:0] KEY_CLOSE = 8'hAA;
    localparam logic [7:0] CHIP_ID   = 8'h02;
    localparam logic [7:0] FLOAT_BUS = 8'hFF;

    // register indices
    localparam logic [7:0] IX_LDN     = 8'h07;
    localparam logic [7:0] IX_ID      = 8'h20;
    localparam logic [7:0] IX_REV     = 8'h21;
    localparam logic [7:0] IX_PWR     = 8'h22;
    localparam logic [7:0] IX_PM      = 8'h23;
    localparam logic [7:0] IX_OSC     = 8'h24;
    localparam logic [7:0] IX_ACT     = 8'h30;
    localparam logic [7:0] IX_BASE_HI = 8'h60;
    localparam logic [7:0] IX_BASE_LO = 8'h61;
    localparam logic [7:0] IX_IRQ_A   = 8'h70;
    localparam logic [7:0] IX_IRQ_B   = 8'h72;
    localparam logic [7:0] IX_DMA     = 8'h74;
    localparam logic [7:0] IX_FMODE   = 8'h90;
    localparam logic [7:0] IX_FOPT    = 8'h91;

    // logical device numbers with optional registers
    localparam int DEV_FDC = 0;
    localparam int DEV_PAR = 3;
    localparam int DEV_KBD = 7;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
        logic idx_rd;
        logic dat_rd;
    } port_op_t;

    typedef struct packed {
        logic        active;
        logic [15:0] base;
        logic [7:0]  irq_a;
        logic [7:0]  irq_b;
        logic [7:0]  dma;
        logic [7:0]  mode;
        logic [7:0]  option;
    } dev_cfg_t;

    function automatic bit has_irq_b(input int dev);
        return dev == DEV_KBD;
    endfunction

    function automatic bit has_dma(input int dev);
        return (dev == DEV_FDC) || (dev == DEV_PAR);
    endfunction

    function automatic bit has_fdd_regs(input int dev);
        return dev == DEV_FDC;
    endfunction

endpackage

// File: rtl/kcfg_port_decode.sv
module kcfg_port_decode
    import kcfg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h0370
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output port_op_t          op_o
);

    logic [ADDR_W-1:0] base_q;
    logic              hit_idx;
    logic              hit_dat;

    // strap captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= base_sel_i ? BASE_ALT : BASE_PRI;
        end
    end

    always_comb begin
        hit_idx = (addr_i == base_q);
        hit_dat = (addr_i == (base_q + ADDR_W'(1)));
        op_o.idx_wr = wr_i && hit_idx && !rst;
        op_o.dat_wr = wr_i && hit_dat && !rst;
        op_o.idx_rd = rd_i && hit_idx && !rst;
        op_o.dat_rd = rd_i && hit_dat && !rst;
    end

    p_single_port_r4: assert property (@(posedge clk) disable iff (rst)
        !(op_o.idx_wr && op_o.dat_wr) && !(op_o.idx_rd && op_o.dat_rd));

endmodule

// File: rtl/kcfg_lock.sv
module kcfg_lock
    import kcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr_i,
    input  logic [7:0] wdata_i,
    output logic       open_o,
    output logic [7:0] idx_o
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (idx_wr_i) begin
            unique case (state_q)
                LK_IDLE: state_d = (wdata_i == KEY_OPEN) ? LK_HALF : LK_IDLE;
                LK_HALF: state_d = (wdata_i == KEY_OPEN) ? LK_OPEN : LK_IDLE;
                LK_OPEN: state_d = (wdata_i == KEY_CLOSE) ? LK_IDLE : LK_OPEN;
                default: state_d = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_IDLE;
            idx_o   <= '0;
        end else begin
            state_q <= state_d;
            if (idx_wr_i && state_q == LK_OPEN && wdata_i != KEY_CLOSE) begin
                idx_o <= wdata_i;
            end
        end
    end

    assign open_o = (state_q == LK_OPEN);

    p_open_on_key_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> ($past(idx_wr_i) && $past(wdata_i) == KEY_OPEN));

    p_stay_locked_r1: assert property (@(posedge clk) disable iff (rst)
        (!open_o && !idx_wr_i) |=> !open_o);

    p_close_key_r2: assert property (@(posedge clk) disable iff (rst)
        (open_o && idx_wr_i && wdata_i == KEY_CLOSE) |=> (!open_o && $stable(idx_o)));

endmodule

// File: rtl/kcfg_global.sv
module kcfg_global
    import kcfg_pkg::*;
#(
    parameter int         NUM_DEV  = 9,
    parameter int         LDN_W    = 4,
    parameter int         PWR_DEVS = 6,
    parameter logic [7:0] REV_VAL  = 8'h01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [7:0]         idx_i,
    input  logic [7:0]         wdata_i,
    input  logic [NUM_DEV-1:0] act_i,
    output logic [LDN_W-1:0]   ldn_o,
    output logic [7:0]         rdata_o
);

    localparam logic [7:0] DEV_LIM = 8'(NUM_DEV);

    logic [LDN_W-1:0] ldn_q;
    logic [7:0]       pm_q;
    logic [7:0]       osc_q;
    logic [7:0]       pwr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ldn_q <= '0;
            pm_q  <= '0;
            osc_q <= '0;
        end else if (wr_i) begin
            case (idx_i)
                IX_LDN: if (wdata_i < DEV_LIM) ldn_q <= wdata_i[LDN_W-1:0];
                IX_PM:  pm_q  <= wdata_i;
                IX_OSC: osc_q <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        pwr = '0;
        pwr[PWR_DEVS-1:0] = act_i[PWR_DEVS-1:0];
    end

    always_comb begin
        rdata_o = '0;
        case (idx_i)
            IX_LDN: rdata_o = {{(8-LDN_W){1'b0}}, ldn_q};
            IX_ID:  rdata_o = CHIP_ID;
            IX_REV: rdata_o = REV_VAL;
            IX_PWR: rdata_o = pwr;
            IX_PM:  rdata_o = pm_q;
            IX_OSC: rdata_o = osc_q;
            default: ;
        endcase
    end

    assign ldn_o = ldn_q;

    p_ldn_range_r7: assert property (@(posedge clk) disable iff (rst)
        ({{(32-LDN_W){1'b0}}, ldn_o} < NUM_DEV));

    p_ldn_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && idx_i == IX_LDN && wdata_i >= DEV_LIM) |=> $stable(ldn_o));

endmodule

// File: rtl/kcfg_dev_bank.sv
module kcfg_dev_bank
    import kcfg_pkg::*;
#(
    parameter int DEV_ID = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_i,
    input  logic       wr_i,
    input  logic [7:0] idx_i,
    input  logic [7:0] wdata_i,
    output dev_cfg_t   cfg_o,
    output logic [7:0] rdata_o
);

    localparam bit HAS_B   = has_irq_b(DEV_ID);
    localparam bit HAS_DMA = has_dma(DEV_ID);
    localparam bit HAS_FDD = has_fdd_regs(DEV_ID);

    dev_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_i && sel_i) begin
            case (idx_i)
                IX_ACT:     cfg_q.active     <= wdata_i[0];
                IX_BASE_HI: cfg_q.base[15:8] <= wdata_i;
                IX_BASE_LO: cfg_q.base[7:0]  <= wdata_i;
                IX_IRQ_A:   cfg_q.irq_a      <= wdata_i;
                IX_IRQ_B:   if (HAS_B)   cfg_q.irq_b  <= wdata_i;
                IX_DMA:     if (HAS_DMA) cfg_q.dma    <= wdata_i;
                IX_FMODE:   if (HAS_FDD) cfg_q.mode   <= wdata_i;
                IX_FOPT:    if (HAS_FDD) cfg_q.option <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (idx_i)
            IX_ACT:     rdata_o = {7'b0, cfg_q.active};
            IX_BASE_HI: rdata_o = cfg_q.base[15:8];
            IX_BASE_LO: rdata_o = cfg_q.base[7:0];
            IX_IRQ_A:   rdata_o = cfg_q.irq_a;
            IX_IRQ_B:   if (HAS_B)   rdata_o = cfg_q.irq_b;
            IX_DMA:     if (HAS_DMA) rdata_o = cfg_q.dma;
            IX_FMODE:   if (HAS_FDD) rdata_o = cfg_q.mode;
            IX_FOPT:    if (HAS_FDD) rdata_o = cfg_q.option;
            default: ;
        endcase
    end

    assign cfg_o = cfg_q;

    p_unselected_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> $stable(cfg_o));

    p_absent_fields_r9: assert property (@(posedge clk) disable iff (rst)
        ((HAS_B || cfg_o.irq_b == 8'h00) && (HAS_DMA || cfg_o.dma == 8'h00)
         && (HAS_FDD || (cfg_o.mode == 8'h00 && cfg_o.option == 8'h00))));

endmodule

// File: rtl/kcfg_top.sv
module kcfg_top
    import kcfg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h0370,
    parameter int                NUM_DEV  = 9,
    parameter int                PWR_DEVS = 6,
    parameter logic [7:0]        REV_VAL  = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  base_sel_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [7:0]            wdata_i,
    output logic [7:0]            rdata_o,
    output logic [NUM_DEV-1:0]    dev_active_o,
    output logic [NUM_DEV*16-1:0] dev_base_o,
    output logic [NUM_DEV*8-1:0]  dev_irq_o,
    output logic [7:0]            kbd_irq2_o,
    output logic [7:0]            fdc_dma_o,
    output logic [7:0]            par_dma_o,
    output logic [7:0]            fdc_mode_o,
    output logic [7:0]            fdc_opt_o
);

    localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    port_op_t         op;
    logic             lk_open;
    logic [7:0]       idx_q;
    logic [LDN_W-1:0] ldn;
    logic             cfg_wr;
    logic [7:0]       glob_rd;
    logic [7:0]       bank_sel_rd;
    logic [7:0]       dat_val;
    logic [7:0]       rdata_q;

    dev_cfg_t   bank_cfg [NUM_DEV];
    logic [7:0] bank_rd  [NUM_DEV];

    kcfg_port_decode #(
        .ADDR_W  (ADDR_W),
        .BASE_PRI(BASE_PRI),
        .BASE_ALT(BASE_ALT)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .base_sel_i(base_sel_i),
        .addr_i    (addr_i),
        .wr_i      (wr_i),
        .rd_i      (rd_i),
        .op_o      (op)
    );

    kcfg_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .idx_wr_i(op.idx_wr),
        .wdata_i (wdata_i),
        .open_o  (lk_open),
        .idx_o   (idx_q)
    );

    assign cfg_wr = lk_open && op.dat_wr;

    kcfg_global #(
        .NUM_DEV (NUM_DEV),
        .LDN_W   (LDN_W),
        .PWR_DEVS(PWR_DEVS),
        .REV_VAL (REV_VAL)
    ) u_global (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (cfg_wr),
        .idx_i  (idx_q),
        .wdata_i(wdata_i),
        .act_i  (dev_active_o),
        .ldn_o  (ldn),
        .rdata_o(glob_rd)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        kcfg_dev_bank #(.DEV_ID(g)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .sel_i  (ldn == LDN_W'(g)),
            .wr_i   (cfg_wr),
            .idx_i  (idx_q),
            .wdata_i(wdata_i),
            .cfg_o  (bank_cfg[g]),
            .rdata_o(bank_rd[g])
        );
        assign dev_active_o[g]          = bank_cfg[g].active;
        assign dev_base_o[g*16 +: 16]   = bank_cfg[g].base;
        assign dev_irq_o[g*8 +: 8]      = bank_cfg[g].irq_a;
    end

    assign kbd_irq2_o = bank_cfg[DEV_KBD].irq_b;
    assign fdc_dma_o  = bank_cfg[DEV_FDC].dma;
    assign par_dma_o  = bank_cfg[DEV_PAR].dma;
    assign fdc_mode_o = bank_cfg[DEV_FDC].mode;
    assign fdc_opt_o  = bank_cfg[DEV_FDC].option;

    always_comb begin
        bank_sel_rd = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (ldn == LDN_W'(d)) bank_sel_rd = bank_rd[d];
        end
        dat_val = (idx_q >= IX_ACT) ? bank_sel_rd : glob_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= FLOAT_BUS;
        end else if (rd_i) begin
            if (op.idx_rd)      rdata_q <= lk_open ? idx_q : FLOAT_BUS;
            else if (op.dat_rd) rdata_q <= lk_open ? dat_val : FLOAT_BUS;
            else                rdata_q <= FLOAT_BUS;
        end
    end

    assign rdata_o = rdata_q;

    p_locked_wr_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (!lk_open && op.dat_wr) |=> ($stable(dev_active_o) && $stable(dev_base_o)
                                     && $stable(dev_irq_o) && $stable(fdc_mode_o)));

    p_locked_rd_float_r3: assert property (@(posedge clk) disable iff (rst)
        (!lk_open && (op.dat_rd || op.idx_rd)) |=> (rdata_o == FLOAT_BUS));

    p_miss_rd_float_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !op.idx_rd && !op.dat_rd) |=> (rdata_o == FLOAT_BUS));

    p_power_mirror_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_i && op.dat_rd && lk_open && idx_q == IX_PWR)
            |=> (rdata_o == {2'b00, $past(dev_active_o[5:0])}));

endmodule

// File: tb/tb_kcfg_top.sv
module tb_kcfg_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         base_sel = 1'b0;
    logic [15:0]  addr = '0;
    logic         wr = 1'b0;
    logic         rd = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [8:0]   dev_active;
    logic [143:0] dev_base;
    logic [71:0]  dev_irq;
    logic [7:0]   kbd_irq2, fdc_dma, par_dma, fdc_mode, fdc_opt;

    int checks = 0;
    int fails  = 0;
    logic [15:0] cur_base = 16'h03F0;

    always #5 clk = ~clk;

    kcfg_top dut (
        .clk         (clk),
        .rst         (rst),
        .base_sel_i  (base_sel),
        .addr_i      (addr),
        .wr_i        (wr),
        .rd_i        (rd),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .dev_active_o(dev_active),
        .dev_base_o  (dev_base),
        .dev_irq_o   (dev_irq),
        .kbd_irq2_o  (kbd_irq2),
        .fdc_dma_o   (fdc_dma),
        .par_dma_o   (par_dma),
        .fdc_mode_o  (fdc_mode),
        .fdc_opt_o   (fdc_opt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        base_sel = strap;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cur_base = strap ? 16'h0370 : 16'h03F0;
    endtask

    // one-cycle write strobe, driven on the falling edge
    task automatic port_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // registered read: data valid at the falling edge after the strobe edge
    task automatic port_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
        port_wr(cur_base, idx);
        port_wr(cur_base + 16'd1, d);
    endtask

    task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] d);
        port_wr(cur_base, idx);
        port_rd(cur_base + 16'd1, d);
    endtask

    task automatic unlock();
        port_wr(cur_base, 8'h55);
        port_wr(cur_base, 8'h55);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset(1'b0);
        chk_eq("R13 active after reset", 32'(dev_active), 32'h0);
        chk_eq("R13 bases after reset", 32'(dev_base[4*16 +: 16]), 32'h0);
        chk_eq("R13 fdc mode after reset", 32'(fdc_mode), 32'h0);
        port_rd(cur_base + 16'd1, d);
        chk_eq("R3 locked data read", 32'(d), 32'hFF);
        port_rd(cur_base, d);
        chk_eq("R3 locked index read", 32'(d), 32'hFF);
    endtask

    task automatic t_unlock_seq();
        logic [7:0] d;
        port_wr(cur_base, 8'h55);
        port_wr(cur_base, 8'h12);
        port_wr(cur_base, 8'h55);
        port_rd(cur_base + 16'd1, d);
        chk_eq("R1 broken key keeps lock", 32'(d), 32'hFF);
        port_wr(cur_base, 8'h55);
        port_wr(cur_base, IX_ID_T);
        port_rd(cur_base + 16'd1, d);
        chk_eq("R1 two keys open, R6 chip id", 32'(d), 32'h02);
        port_rd(cur_base, d);
        chk_eq("R5 index readback", 32'(d), 32'h20);
    endtask

    localparam logic [7:0] IX_ID_T = 8'h20;

    task automatic t_globals();
        logic [7:0] d;
        cfg_rd(8'h21, d);
        chk_eq("R6 revision", 32'(d), 32'h01);
        cfg_wr(8'h20, 8'h77);
        cfg_rd(8'h20, d);
        chk_eq("R6 id ignores write", 32'(d), 32'h02);
        cfg_wr(8'h23, 8'hA5);
        cfg_wr(8'h24, 8'h3C);
        cfg_rd(8'h23, d);
        chk_eq("R6 power mgmt rw", 32'(d), 32'hA5);
        cfg_rd(8'h24, d);
        chk_eq("R6 osc rw", 32'(d), 32'h3C);
    endtask

    task automatic t_ldn();
        logic [7:0] d;
        cfg_wr(8'h07, 8'h05);
        cfg_rd(8'h07, d);
        chk_eq("R7 ldn store", 32'(d), 32'h05);
        cfg_wr(8'h07, 8'h09);
        cfg_rd(8'h07, d);
        chk_eq("R7 ldn out of range ignored", 32'(d), 32'h05);
        cfg_wr(8'h07, 8'h08);
        cfg_rd(8'h07, d);
        chk_eq("R7 ldn max", 32'(d), 32'h08);
    endtask

    task automatic t_dev_banks();
        logic [7:0] d;
        cfg_wr(8'h07, 8'h04);
        cfg_wr(8'h60, 8'h03);
        cfg_wr(8'h61, 8'hF8);
        cfg_wr(8'h70, 8'h04);
        port_wr(cur_base, 8'h30);
        port_wr(cur_base + 16'd1, 8'h01);
        chk_eq("R14 active visible after write edge", 32'(dev_active[4]), 32'h1);
        chk_eq("R8 serial1 base", 32'(dev_base[4*16 +: 16]), 32'h03F8);
        chk_eq("R8 serial1 irq", 32'(dev_irq[4*8 +: 8]), 32'h04);
        chk_eq("R8 serial2 untouched", 32'(dev_base[5*16 +: 16]), 32'h0);
        cfg_wr(8'h07, 8'h05);
        cfg_wr(8'h60, 8'h02);
        cfg_wr(8'h61, 8'hF8);
        cfg_wr(8'h70, 8'h03);
        cfg_rd(8'h61, d);
        chk_eq("R8 serial2 base low readback", 32'(d), 32'hF8);
        chk_eq("R8 serial1 kept", 32'(dev_base[4*16 +: 16]), 32'h03F8);
        chk_eq("R8 serial2 irq", 32'(dev_irq[5*8 +: 8]), 32'h03);
        cfg_rd(8'h30, d);
        chk_eq("R8 serial2 inactive", 32'(d), 32'h00);
    endtask

    task automatic t_optional_regs();
        logic [7:0] d;
        cfg_wr(8'h07, 8'h07);
        cfg_wr(8'h72, 8'h0C);
        chk_eq("R9 kbd secondary irq", 32'(kbd_irq2), 32'h0C);
        cfg_wr(8'h74, 8'h02);
        cfg_rd(8'h74, d);
        chk_eq("R9 kbd has no dma", 32'(d), 32'h00);
        chk_eq("R9 dma outputs unchanged", 32'({fdc_dma, par_dma}), 32'h0);
        cfg_wr(8'h07, 8'h04);
        cfg_wr(8'h72, 8'h09);
        cfg_rd(8'h72, d);
        chk_eq("R9 serial has no irq2", 32'(d), 32'h00);
        chk_eq("R9 kbd irq2 kept", 32'(kbd_irq2), 32'h0C);
        cfg_wr(8'h07, 8'h00);
        cfg_wr(8'h74, 8'h02);
        cfg_wr(8'h07, 8'h03);
        cfg_wr(8'h74, 8'h01);
        chk_eq("R9 fdc dma", 32'(fdc_dma), 32'h02);
        chk_eq("R9 parallel dma", 32'(par_dma), 32'h01);
    endtask

    task automatic t_fdd_mode();
        logic [7:0] d;
        cfg_wr(8'h07, 8'h00);
        cfg_wr(8'h90, 8'h41);
        cfg_rd(8'h90, d);
        chk_eq("R10 mode readback", 32'(d), 32'h41);
        port_wr(cur_base + 16'd1, d | 8'h0E);
        chk_eq("R10 mode read-modify-write", 32'(fdc_mode), 32'h4F);
        cfg_wr(8'h91, 8'hC3);
        chk_eq("R10 option", 32'(fdc_opt), 32'hC3);
        cfg_wr(8'h07, 8'h01);
        cfg_wr(8'h90, 8'h11);
        cfg_rd(8'h90, d);
        chk_eq("R10 ide1 has no mode", 32'(d), 32'h00);
        chk_eq("R10 fdc mode kept", 32'(fdc_mode), 32'h4F);
    endtask

    task automatic t_power();
        logic [7:0] d;
        cfg_wr(8'h07, 8'h00);
        cfg_wr(8'h30, 8'h01);
        cfg_wr(8'h07, 8'h07);
        cfg_wr(8'h30, 8'h01);
        cfg_rd(8'h22, d);
        chk_eq("R11 power mirror", 32'(d), 32'h11);
        cfg_wr(8'h22, 8'hFF);
        cfg_rd(8'h22, d);
        chk_eq("R11 power read-only", 32'(d), 32'h11);
    endtask

    task automatic t_unimplemented();
        logic [7:0] d;
        cfg_wr(8'h07, 8'h00);
        cfg_wr(8'h50, 8'h5A);
        cfg_rd(8'h50, d);
        chk_eq("R12 unimplemented bank index", 32'(d), 32'h00);
        cfg_wr(8'h2A, 8'h5A);
        cfg_rd(8'h2A, d);
        chk_eq("R12 unimplemented global index", 32'(d), 32'h00);
        chk_eq("R12 outputs untouched", 32'(fdc_mode), 32'h4F);
    endtask

    task automatic t_relock();
        logic [7:0] d;
        port_wr(cur_base, 8'h30);
        port_wr(cur_base, 8'hAA);
        port_wr(cur_base + 16'd1, 8'h00);
        chk_eq("R2 relock blocks data write", 32'(dev_active[0]), 32'h1);
        port_rd(cur_base + 16'd1, d);
        chk_eq("R3 relocked data read", 32'(d), 32'hFF);
        unlock();
        port_rd(cur_base, d);
        chk_eq("R2 index kept across relock", 32'(d), 32'h30);
    endtask

    task automatic t_alt_base();
        logic [7:0] d;
        do_reset(1'b1);
        base_sel = 1'b0;
        port_wr(16'h03F0, 8'h55);
        port_wr(16'h03F0, 8'h55);
        port_rd(16'h0371, d);
        chk_eq("R4 primary address unused", 32'(d), 32'hFF);
        unlock();
        port_wr(16'h0370, 8'h20);
        port_rd(16'h0371, d);
        chk_eq("R4 alternate base id", 32'(d), 32'h02);
        port_rd(16'h03F1, d);
        chk_eq("R4 miss read floats", 32'(d), 32'hFF);
        cfg_wr(8'h07, 8'h03);
        port_wr(16'h03F0, 8'h30);
        port_wr(16'h03F1, 8'h01);
        chk_eq("R4 miss write ignored", 32'(dev_active), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_unlock_seq();
        t_globals();
        t_ldn();
        t_dev_banks();
        t_optional_regs();
        t_fdd_mode();
        t_power();
        t_unimplemented();
        t_relock();
        t_alt_base();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule